// File: doc/BRIEF.md
# Synchronizing Single-Pulse Button Conditioner

This block takes the level from a push-button, which changes with no relation to the system clock and stays high for milliseconds, and turns each press into exactly one pulse that is one clock period wide. The raw level first passes through a chain of rising-edge D flip-flops that synchronize it. A three-state machine with one input and one output then follows the synchronized level. It is armed while the button is released. It fires for one cycle when the level rises. It then holds until the level drops again, and only after that is it armed once more.

The pulse leaves the block from a register clocked on the falling edge. A consumer that is clocked on the rising edge therefore samples a signal that settled half a period earlier and stays put for another half period, which gives setup and hold margin in both directions. The input may be a raw contact or a level that has already been debounced. Bounce filtering is not part of this block.

Top module: `btn_pulse_shaper`

## Requirements
- R1: The button level is sampled only through a chain of SYNC_STAGES rising-edge flip-flops (default 2). When the level first rises and is first sampled at rising edge k, pulse_o goes high at the falling edge that follows rising edge k+SYNC_STAGES.
- R2: A press gives exactly one pulse, however many cycles the button stays high.
- R3: pulse_o is high for exactly one clock period, from one falling edge to the next one.
- R4: pulse_o changes only at falling clock edges. It is the same just before and just after every rising edge.
- R5: While the synchronized level stays high after a pulse, no further pulse is produced.
- R6: If the button returns low for at least one rising edge and then rises again, a new pulse is produced, at the latency given in R1 counted from the new rise.
- R7: rst_i is synchronous and active high. Any rising edge that samples it high clears the synchronizer and arms the machine. pulse_o is low from the next falling edge on. A button that is still held when reset ends is treated as a fresh press.
- R8: A press that is sampled high at only one rising edge still produces exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock. The synchronizer and the state machine use its rising edge, the output register uses its falling edge |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_i | input | 1 | Button level, asynchronous to clk_i, high while pressed |
| pulse_o | output | 1 | One-period pulse per press, launched on the falling edge |

## Verification
On every cycle the assertions check the following. A fire cycle always comes from a high synchronized level, and two fire cycles are never adjacent. Nothing fires while the synchronized level has been high for two edges in a row. The falling-edge output matches the fire state at each rising edge, is never high at two rising edges in a row, and is low after any reset cycle. Only the bench scenarios can show the absolute latency from the button to the pulse, the one-pulse-per-press count over long holds, re-arming after a single low cycle, and a held button being taken as a new press once reset ends. The scoreboard predicts these from the cycle at which each stimulus is applied.

// File: rtl/btnp_pkg.sv
`timescale 1ns/1ps
package btnp_pkg;

    // Press tracker states
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,   // released, waiting for a rise
        ST_FIRE  = 2'd1,   // single cycle that produces the pulse
        ST_HELD  = 2'd2    // pulse given, waiting for release
    } press_state_e;

    typedef struct packed {
        press_state_e state;
    } press_regs_t;

endpackage

// File: rtl/btnp_sync.sv
`timescale 1ns/1ps
module btnp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic level_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        if (rst_i) begin
            chain_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        chain_q <= chain_d;
    end

    assign level_o = chain_q[LAST];

endmodule

// File: rtl/btnp_press_fsm.sv
`timescale 1ns/1ps
module btnp_press_fsm
    import btnp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic fire_o
);

    press_regs_t r_d;
    press_regs_t r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_ARMED: if (level_i) r_d.state = ST_FIRE;
            ST_FIRE:  r_d.state = level_i ? ST_HELD : ST_ARMED;
            ST_HELD:  if (!level_i) r_d.state = ST_ARMED;
            default:  r_d.state = ST_ARMED;
        endcase
        if (rst_i) begin
            r_d.state = ST_ARMED;
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign fire_o = (r_q.state == ST_FIRE);

endmodule

// File: rtl/btnp_fall_launch.sv
`timescale 1ns/1ps
module btnp_fall_launch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fire_i,
    output logic pulse_o
);

    logic pulse_d;
    logic pulse_q;

    always_comb begin
        pulse_d = fire_i;
        if (rst_i) begin
            pulse_d = 1'b0;
        end
    end

    // Launch half a period ahead of the rising-edge consumer
    always_ff @(negedge clk_i) begin
        pulse_q <= pulse_d;
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/btn_pulse_shaper.sv
`timescale 1ns/1ps
module btn_pulse_shaper #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic btn_i,
    output logic pulse_o
);

    logic sync_lvl;
    logic fire;

    btnp_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (btn_i),
        .level_o (sync_lvl)
    );

    btnp_press_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (sync_lvl),
        .fire_o  (fire)
    );

    btnp_fall_launch u_launch (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .fire_i  (fire),
        .pulse_o (pulse_o)
    );

endmodule

// File: rtl/btnp_checker.sv
`timescale 1ns/1ps
module btnp_checker (
    input logic clk_i,
    input logic rst_i,
    input logic sync_lvl,
    input logic fire,
    input logic pulse_o
);

    // R2: a fire cycle needs a high synchronized level one edge earlier
    a_r2_fire_from_level: assert property (@(posedge clk_i) disable iff (rst_i)
        fire |-> $past(sync_lvl));

    // R2: never two fire cycles in a row
    a_r2_no_back_to_back: assert property (@(posedge clk_i) disable iff (rst_i)
        fire |=> !fire);

    // R5: a level that stays high keeps the machine quiet
    a_r5_held_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(sync_lvl, 2) && $past(sync_lvl)) |-> !fire);

    // R4: the falling-edge output mirrors the fire state at each rising edge
    a_r4_fall_launch: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (pulse_o == fire));

    // R3: one period wide
    a_r3_one_period: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o);

    // R7: a reset cycle leaves everything quiet
    a_r7_reset_clears: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!pulse_o && !fire));

endmodule

bind btn_pulse_shaper btnp_checker u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .sync_lvl (sync_lvl),
    .fire     (fire),
    .pulse_o  (pulse_o)
);

// File: tb/tb_btn_pulse_shaper.sv
`timescale 1ns/1ps
module tb_btn_pulse_shaper;

    localparam int SYNC_STAGES = 2;
    localparam int LAT         = SYNC_STAGES + 2;  // cycles from drive to high mid-cycle sample

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn = 1'b0;
    logic pulse;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int n_pushed = 0;
    int n_seen = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    logic prev_b = 1'b0;
    int exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    btn_pulse_shaper #(.SYNC_STAGES(SYNC_STAGES)) dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .btn_i   (btn),
        .pulse_o (pulse)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Driver: all inputs change 1 ns after a falling edge
    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic press(input int hold, input int gap);
        step(1);
        btn = 1'b1;
        exp_q.push_back(cyc + LAT);   // R1 latency
        n_pushed++;
        step(hold);
        btn = 1'b0;
        if (gap > 0) repeat (gap) @(negedge clk);
    endtask

    // Monitor, falling-edge side (2 ns after negedge)
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_en) begin
                if (prev_b === 1'b1) chk("R3 low after one period", int'(pulse), 0);
                prev_b = pulse;
            end
        end
    end

    // Monitor, rising-edge side (2 ns after posedge)
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_en) begin
                if (pulse === 1'b1 || prev_b === 1'b1)
                    chk("R4 no change at rising edge", int'(pulse), int'(prev_b));
                if (pulse === 1'b1) begin
                    n_seen++;
                    if (exp_q.size() == 0) begin
                        chk("R2/R5 unexpected pulse at cycle", cyc, -1);
                    end else begin
                        chk("R1/R6 pulse cycle", cyc, exp_q.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R7 reset output low", int'(pulse), 0);
        rst = 1'b0;
        step(1);
        mon_en = 1'b1;
        chk("R7 idle output low", int'(pulse), 0);

        // R1/R2 ordinary press
        press(20, 10);
        // R2/R5 long hold gives one pulse
        press(300, 10);
        // R8 single-edge press
        press(1, 8);
        // R6 minimum release of one edge between presses
        press(6, 0);
        press(5, 6);
        // R8 + R6 back-to-back single-edge presses
        press(1, 0);
        press(1, 8);

        // R7 reset during a press, button still held afterwards
        step(1);
        btn = 1'b1;
        step(1);
        rst = 1'b1;
        step(1);
        chk("R7 output low in reset", int'(pulse), 0);
        step(2);
        rst = 1'b0;
        exp_q.push_back(cyc + LAT);
        n_pushed++;
        step(30);
        btn = 1'b0;
        step(10);

        // R5 press held across many cycles after a short one
        press(2, 3);
        press(100, 12);

        step(LAT + 6);
        chk("R2 pending pulses", exp_q.size(), 0);
        chk("R2 one pulse per press", n_seen, n_pushed);
        chk("R7 final output low", int'(pulse), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule